// File: doc/BRIEF.md
# Dual-Channel Threshold Zero Suppressor

This block removes quiet channels from a detector event before the event is packed. An event is a fixed run of data words: four links of 32 words, in link order and then word order. Every 20-bit word holds two 10-bit channels. The upper channel is in bits 19:10 and the lower channel is in bits 9:0. Each channel value is a 2-bit trigger field above an 8-bit ADC value, and the whole 10-bit value is compared. An internal RAM has one word for each data word. Each RAM word packs the two matching thresholds in the same bit layout as the data. A channel leaves the block only when its value is strictly above its threshold. A threshold of 0x3FF can therefore never be exceeded, so writing it masks that channel.

Surviving channels leave on two output lanes, with no stall. Lane 0 carries the upper channel of a word and lane 1 carries the lower one, so one cycle holds at most the two neighbouring channels of a single word. Reading lane 0 before lane 1, cycle by cycle, gives the kept channels in ascending address order. After the last word's result, a single end-of-event cycle follows. The sequencer has five states:
- IDLE: waits for the first word; it goes to COLLECT when a word arrives.
- COLLECT: counts accepted words; it goes to TAIL when the final word is accepted.
- TAIL: the final word waits for its threshold read; it always goes to EMIT.
- EMIT: the final word's result is on the lanes; it always goes to MARK.
- MARK: the end-of-event marker is shown; it goes back to IDLE.

Top module: `zs_suppressor_top`

## Requirements
- R1: While reset is held, and at the first sample after release, `busy`, `out_valid` and `out_eoe` are all 0.
- R2: For a data word with global index w = link*32 + word, the upper channel (bits 19:10) leaves on lane 0 with address 2w. The lower channel (bits 9:0) leaves on lane 1 with address 2w+1. The 8-bit address is therefore {link[1:0], word[4:0], half}, where half is 0 for the upper channel.
- R3: A channel is reported only when its 10-bit value is strictly greater than its threshold; a value equal to the threshold is dropped.
- R4: A threshold of 0x3FF masks its channel: no data value is ever reported for it.
- R5: Threshold RAM word w (write address w, 7 bits) applies to data word w. Its bits 19:10 are the upper channel's threshold and bits 9:0 are the lower channel's threshold.
- R6: A word sampled at a rising edge shows its lane results after the second following rising edge, and not after the first.
- R7: An event is exactly 128 accepted words. Cycles with `in_valid` low neither advance nor end the event.
- R8: `out_eoe` is a one-cycle pulse. It comes in the cycle right after the last word's lane results, and no lane is valid in that cycle.
- R9: `busy` rises at the edge that accepts an event's first word. It stays high through the `out_eoe` cycle and is low in the next cycle.
- R10: Threshold writes are ignored while `busy` or `in_valid` is high. Words presented while `busy` is high after the final word are ignored and do not start a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_addr | input | 7 | Threshold RAM word index (link*32 + word) |
| cfg_data | input | 20 | Two packed thresholds, upper channel in 19:10 |
| in_valid | input | 1 | Data word present |
| in_data | input | 20 | Two packed channel values |
| busy | output | 1 | Event in progress |
| out_valid | output | 2 | Lane valid flags, bit 0 is the upper-channel lane |
| out_addr0 | output | 8 | Channel address on lane 0 |
| out_val0 | output | 10 | Channel value on lane 0 |
| out_addr1 | output | 8 | Channel address on lane 1 |
| out_val1 | output | 10 | Channel value on lane 1 |
| out_eoe | output | 1 | End-of-event pulse |

## Verification
The bench builds the block with its default sizes: four links of 32 words and 10-bit channels. This keeps the full 256-channel event and the whole 128-word threshold RAM small enough to sweep in every run. Every channel of every event is compared against a list computed arithmetically in the bench. The bench loads two complete threshold maps. It drives value patterns that sit exactly at the threshold, one above it, at 0x3FF and spread pseudo-randomly. This exercises the strict comparison, masking and both halves of every RAM word. Gaps in `in_valid`, a threshold write during an event and extra words after the final word test the event bounds and the write lockout.

// File: rtl/zs_pkg.sv
package zs_pkg;

    // Sequencer states of the suppressor
    typedef enum logic [2:0] {
        ZS_IDLE    = 3'd0,
        ZS_COLLECT = 3'd1,
        ZS_TAIL    = 3'd2,
        ZS_EMIT    = 3'd3,
        ZS_MARK    = 3'd4
    } zs_state_e;

    localparam int ZS_LANES = 2;

endpackage

// File: rtl/zs_thr_ram.sv
module zs_thr_ram #(
    parameter  int DEPTH = 128,
    parameter  int DW    = 20,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Single write port, registered read: one cycle of read latency
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/zs_seq.sv
module zs_seq
    import zs_pkg::*;
#(
    parameter  int TOT_WORDS = 128,
    localparam int IDX_W     = $clog2(TOT_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             cfg_we,
    output logic             take,
    output logic [IDX_W-1:0] word_idx,
    output logic             busy,
    output logic             eoe,
    output logic             wr_ok
);

    zs_state_e        state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic             final_word;

    // Word acceptance is decided by the current state only
    always_comb begin
        take       = in_valid && (state_q == ZS_IDLE || state_q == ZS_COLLECT);
        final_word = take && (cnt_q == IDX_W'(TOT_WORDS - 1));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ZS_IDLE: begin
                if (take) begin
                    state_d = final_word ? ZS_TAIL : ZS_COLLECT;
                end
            end
            ZS_COLLECT: begin
                if (final_word) begin
                    state_d = ZS_TAIL;
                end
            end
            ZS_TAIL:  state_d = ZS_EMIT;
            ZS_EMIT:  state_d = ZS_MARK;
            ZS_MARK:  state_d = ZS_IDLE;
            default:  state_d = ZS_IDLE;
        endcase
    end

    // State register and word counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ZS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                cnt_q <= final_word ? '0 : cnt_q + 1'b1;
            end
        end
    end

    // Moore outputs
    always_comb begin
        word_idx = cnt_q;
        busy     = (state_q != ZS_IDLE);
        eoe      = (state_q == ZS_MARK);
        wr_ok    = cfg_we && (state_q == ZS_IDLE) && !in_valid;
    end

endmodule

// File: rtl/zs_lane.sv
module zs_lane #(
    parameter  int CH_W   = 10,
    parameter  int IDX_W  = 7,
    parameter  bit HALF   = 1'b0,
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CH_W-1:0]   value,
    input  logic [CH_W-1:0]   thr,
    input  logic [IDX_W-1:0]  idx,
    output logic              keep,
    output logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   val
);

    logic hit;

    always_comb begin
        hit = en && (value > thr);
    end

    // Registered comparison result; data fields zeroed when dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep <= 1'b0;
            addr <= '0;
            val  <= '0;
        end else begin
            keep <= hit;
            addr <= hit ? {idx, HALF} : '0;
            val  <= hit ? value : '0;
        end
    end

endmodule

// File: rtl/zs_suppressor_top.sv
module zs_suppressor_top
    import zs_pkg::*;
#(
    parameter  int N_LINKS   = 4,
    parameter  int N_WORDS   = 32,
    parameter  int CH_W      = 10,
    localparam int TOT_WORDS = N_LINKS * N_WORDS,
    localparam int IDX_W     = $clog2(TOT_WORDS),
    localparam int ADDR_W    = IDX_W + 1,
    localparam int DW        = ZS_LANES * CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic [DW-1:0]     cfg_data,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_data,
    output logic              busy,
    output logic [1:0]        out_valid,
    output logic [ADDR_W-1:0] out_addr0,
    output logic [CH_W-1:0]   out_val0,
    output logic [ADDR_W-1:0] out_addr1,
    output logic [CH_W-1:0]   out_val1,
    output logic              out_eoe
);

    logic             take;
    logic             wr_ok;
    logic [IDX_W-1:0] word_idx;
    logic [DW-1:0]    thr_word;

    logic             s1_valid;
    logic [DW-1:0]    s1_data;
    logic [IDX_W-1:0] s1_idx;

    logic [ZS_LANES-1:0] lane_keep;
    logic [ADDR_W-1:0]   lane_addr [ZS_LANES];
    logic [CH_W-1:0]     lane_val  [ZS_LANES];

    zs_seq #(.TOT_WORDS(TOT_WORDS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .cfg_we   (cfg_we),
        .take     (take),
        .word_idx (word_idx),
        .busy     (busy),
        .eoe      (out_eoe),
        .wr_ok    (wr_ok)
    );

    zs_thr_ram #(.DEPTH(TOT_WORDS), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (cfg_addr),
        .wdata (cfg_data),
        .re    (take),
        .raddr (word_idx),
        .rdata (thr_word)
    );

    // Data stage aligned with the RAM read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_data  <= '0;
            s1_idx   <= '0;
        end else begin
            s1_valid <= take;
            if (take) begin
                s1_data <= in_data;
                s1_idx  <= word_idx;
            end
        end
    end

    // Lane g handles half g: g = 0 is the upper channel
    for (genvar g = 0; g < ZS_LANES; g++) begin : g_lane
        localparam int HI = DW - 1 - g * CH_W;
        zs_lane #(.CH_W(CH_W), .IDX_W(IDX_W), .HALF(g[0])) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (s1_valid),
            .value (s1_data[HI -: CH_W]),
            .thr   (thr_word[HI -: CH_W]),
            .idx   (s1_idx),
            .keep  (lane_keep[g]),
            .addr  (lane_addr[g]),
            .val   (lane_val[g])
        );
    end

    always_comb begin
        out_valid = lane_keep;
        out_addr0 = lane_addr[0];
        out_val0  = lane_val[0];
        out_addr1 = lane_addr[1];
        out_val1  = lane_val[1];
    end

endmodule

// File: rtl/zs_suppressor_chk.sv
module zs_suppressor_chk #(
    parameter int ADDR_W = 8,
    parameter int CH_W   = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [1:0]        out_valid,
    input logic [ADDR_W-1:0] out_addr0,
    input logic [CH_W-1:0]   out_val0,
    input logic [ADDR_W-1:0] out_addr1,
    input logic              out_eoe
);

    // R9: lane results only appear inside an event
    a_r9_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid != 2'b00) |-> busy);

    // R8: the marker cycle carries no channel
    a_r8_eoe_alone: assert property (@(posedge clk) disable iff (!rst_n)
        out_eoe |-> (out_valid == 2'b00));

    // R8: the marker lasts one cycle
    a_r8_eoe_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_eoe |=> !out_eoe);

    // R9: busy drops right after the marker
    a_r9_idle_after_eoe: assert property (@(posedge clk) disable iff (!rst_n)
        out_eoe |=> !busy);

    // R9: busy only falls after a marker
    a_r9_fall_after_eoe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(out_eoe));

    // R2: lane 0 carries even (upper) addresses, lane 1 odd ones
    a_r2_lane0_even: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[0] |-> !out_addr0[0]);

    a_r2_lane1_odd: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[1] |-> out_addr1[0]);

    // R3: a kept value exceeds some threshold, so it cannot be zero
    a_r3_kept_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[0] |-> (out_val0 != '0));

endmodule

bind zs_suppressor_top zs_suppressor_chk #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .out_valid (out_valid),
    .out_addr0 (out_addr0),
    .out_val0  (out_val0),
    .out_addr1 (out_addr1),
    .out_eoe   (out_eoe)
);

// File: tb/sim_zs_suppressor_top.sv
module sim_zs_suppressor_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [19:0] cfg_data = '0;
    logic        in_valid = 1'b0;
    logic [19:0] in_data = '0;
    logic        busy;
    logic [1:0]  out_valid;
    logic [7:0]  out_addr0, out_addr1;
    logic [9:0]  out_val0, out_val1;
    logic        out_eoe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int got_addr [256];
    int got_val  [256];
    int got_n = 0;
    int exp_addr [256];
    int exp_val  [256];
    int exp_n = 0;
    int eoe_cnt = 0;
    bit eoe_prev = 1'b0;

    always #2 clk = ~clk;

    zs_suppressor_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .in_valid(in_valid), .in_data(in_data),
        .busy(busy), .out_valid(out_valid), .out_addr0(out_addr0),
        .out_val0(out_val0), .out_addr1(out_addr1), .out_val1(out_val1),
        .out_eoe(out_eoe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Threshold maps (R4: 1023 masks)
    function automatic int thr_f(input int m, input int ch);
        if (m == 0) return (ch % 13 == 0) ? 1023 : (ch * 37 + 11) % 1024;
        return (ch % 64 == 63) ? 1023 : ch * 4;
    endfunction

    // Value patterns
    function automatic int pat_f(input int p, input int m, input int ch);
        int t;
        t = thr_f(m, ch);
        case (p)
            0: return (ch * 53 + 7) % 1024;
            1: return 1022;
            2: return t;
            3: return (t == 1023) ? 1023 : t + 1;
            default: return 1023;
        endcase
    endfunction

    // Monitor: collect lane results in ascending order, watch the marker
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid[0] && got_n < 256) begin
                got_addr[got_n] = out_addr0; got_val[got_n] = out_val0; got_n++;
            end
            if (out_valid[1] && got_n < 256) begin
                got_addr[got_n] = out_addr1; got_val[got_n] = out_val1; got_n++;
            end
            if (eoe_prev) begin
                check(!out_eoe, "R8 marker single", out_eoe, 0);
                check(!busy, "R9 busy low after marker", busy, 0);
            end
            if (out_eoe) begin
                check(out_valid == 2'b00, "R8 marker alone", out_valid, 0);
                check(busy, "R9 busy during marker", busy, 1);
                eoe_cnt++;
            end
            eoe_prev = out_eoe;
        end
    end

    task automatic load_thr(input int m);
        for (int w = 0; w < 128; w++) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_addr = 7'(w);
            cfg_data = {10'(thr_f(m, 2 * w)), 10'(thr_f(m, 2 * w + 1))};
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic build_exp(input int m, input int p);
        exp_n = 0;
        for (int ch = 0; ch < 256; ch++) begin
            if (pat_f(p, m, ch) > thr_f(m, ch)) begin
                exp_addr[exp_n] = ch; exp_val[exp_n] = pat_f(p, m, ch); exp_n++;
            end
        end
    endtask

    // Drive words from start_w; optional gaps, mid-event write, trailing words
    task automatic drive_event(input int m, input int p, input int start_w,
                               input bit gaps, input bit poke, input bit trail);
        int e0;
        e0 = eoe_cnt;
        for (int w = start_w; w < 128; w++) begin
            if (gaps && (w % 7 == 3)) begin
                @(negedge clk);
                in_valid = 1'b0; cfg_we = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data = {10'(pat_f(p, m, 2 * w)), 10'(pat_f(p, m, 2 * w + 1))};
            cfg_we = poke && (w == 40);
            cfg_addr = 7'd10; cfg_data = 20'h00000;
        end
        cfg_we = 1'b0;
        if (trail) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                in_valid = 1'b1; in_data = 20'hFFFFF;
                cfg_we = 1'b1; cfg_addr = 7'd11; cfg_data = 20'h00000;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
        while (eoe_cnt == e0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(!busy, "R10 no new event from trailing words", busy, 0);
        check(eoe_cnt == e0 + 1, "R7 one marker per event", eoe_cnt - e0, 1);
    endtask

    task automatic compare(input int m, input int p);
        build_exp(m, p);
        check(got_n == exp_n, (p == 2) ? "R3 equal dropped count" :
              (p == 4) ? "R4 mask count" : "R3 kept count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(got_addr[i] == exp_addr[i], "R2 R5 channel address", got_addr[i], exp_addr[i]);
            check(got_val[i] == exp_val[i], "R2 channel value", got_val[i], exp_val[i]);
        end
    endtask

    task automatic run(input int m, input int p, input bit gaps, input bit poke, input bit trail);
        got_n = 0;
        drive_event(m, p, 0, gaps, poke, trail);
        compare(m, p);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy, "R1 busy in reset", busy, 0);
        check(out_valid == 2'b00, "R1 lanes in reset", out_valid, 0);
        check(!out_eoe, "R1 marker in reset", out_eoe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && out_valid == 2'b00 && !out_eoe, "R1 after release", busy, 0);

        load_thr(1);
        // R6: latency of the first word, then the rest of the event
        got_n = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data = {10'(pat_f(1, 1, 0)), 10'(pat_f(1, 1, 1))};
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 2'b00, "R6 not after first edge", out_valid, 0);
        check(busy, "R9 busy after first word", busy, 1);
        @(negedge clk);
        check(out_valid == 2'b11, "R6 result after second edge", out_valid, 3);
        check(out_addr0 == 8'd0 && out_addr1 == 8'd1, "R2 first word addresses",
              out_addr1, 1);
        repeat (4) @(negedge clk);
        check(busy && !out_eoe, "R7 gap keeps event open", busy, 1);
        drive_event(1, 1, 1, 1'b0, 1'b0, 1'b0);
        compare(1, 1);

        load_thr(0);
        run(0, 0, 1'b1, 1'b1, 1'b1);   // R7 gaps, R10 write and words ignored
        run(0, 0, 1'b0, 1'b0, 1'b0);   // R10 map unchanged by ignored writes
        run(0, 2, 1'b0, 1'b0, 1'b0);   // R3 equal values dropped
        run(0, 3, 1'b1, 1'b0, 1'b0);   // R3 one above kept
        run(0, 4, 1'b0, 1'b0, 1'b0);   // R4 masked channels dropped
        load_thr(1);
        run(1, 0, 1'b0, 1'b0, 1'b1);   // R5 new map applied
        run(1, 3, 1'b1, 1'b0, 1'b0);
        run(1, 4, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule